// File: doc/BRIEF.md
# Interrupt Enable and Acknowledge Unit

This unit is the interrupt front end of a small 8-bit processor core. It holds a global interrupt enable and a three-bit mask for three restart request lines, and it watches a fourth, general request line. The core sets and clears the enable when it executes its enable and disable instructions. It writes the mask with a dedicated strobe. At each instruction boundary the core asks the unit whether an interrupt should be taken.

When a request is both enabled and unmasked, the unit accepts it at the boundary and clears the global enable. It then tells the core what to run next. A restart line produces a fixed vector address internally. The general request line makes the unit drive an active-low acknowledge pulse instead. It latches the instruction byte that external logic drives onto the data bus during the pulse and hands that opcode to the core. If the byte is a restart opcode, the unit also decodes its vector. In that way a byte of E7h leads to the call target 0020h. The core then performs the call as a hardware-initiated subroutine call.

Top module: `irq_ack_unit`

## Requirements
- R1: After reset the global enable is 0 and all three mask bits are 1, so every restart line is blocked. The acknowledge output is high, and take, vector-valid and opcode-valid are all low.
- R2: An enable strobe sets the global enable from the next cycle on, and a disable strobe clears it. If both strobes arrive in the same cycle, the disable wins.
- R3: While the global enable is 0, no request of any kind is taken.
- R4: A mask write loads `mask_wdata_i`. Bit 2 gates the highest restart line, bit 1 the middle line and bit 0 the lowest line, and a 1 blocks its line. The general request line has no mask bit.
- R5: Among the eligible requests, the highest restart line wins, then the middle line, then the lowest line, then the general line.
- R6: The highest restart line is edge-triggered. A rising edge is held until that line is serviced, and a level held high after service does not trigger it again. The middle and lowest lines are level-sensitive, so a pulse that has ended before the boundary is not taken.
- R7: Taking a restart line raises `vec_valid_o` for exactly the following cycle. The address is 003Ch for the highest line, 0034h for the middle line and 002Ch for the lowest line.
- R8: Taking the general line drives `inta_n_o` low for PULSE_CYC cycles, starting in the next cycle. `data_i` is sampled in the last low cycle. `op_valid_o` and `opcode_o` present that byte in the cycle after the acknowledge returns high.
- R9: A byte of the form 11nnn111 that is latched during the acknowledge also raises `vec_valid_o` with the address nnn*8, in the same cycle as `op_valid_o`. Any other byte leaves `vec_valid_o` low.
- R10: Taking any interrupt clears the global enable, and further requests are ignored until the next enable strobe.
- R11: While the acknowledge pulse is in progress, a boundary request is not taken.
- R12: Nothing is taken in a cycle where `boundary_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ei_i | input | 1 | Core executed the enable instruction |
| di_i | input | 1 | Core executed the disable instruction |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 3 | New mask bits (1 = block) |
| irq_hi_i | input | 1 | Highest restart line, edge-triggered |
| irq_mid_i | input | 1 | Middle restart line, level |
| irq_lo_i | input | 1 | Lowest restart line, level |
| intr_i | input | 1 | General request line, level |
| boundary_i | input | 1 | Core is at an instruction boundary |
| data_i | input | 8 | Data bus byte supplied during acknowledge |
| take_o | output | 1 | Interrupt accepted this cycle |
| ie_o | output | 1 | Global interrupt enable |
| inta_n_o | output | 1 | Active-low acknowledge pulse |
| busy_o | output | 1 | Acknowledge pulse in progress |
| vec_valid_o | output | 1 | Call vector valid |
| vec_addr_o | output | 16 | Call vector address |
| op_valid_o | output | 1 | Latched opcode valid |
| opcode_o | output | 8 | Opcode latched during acknowledge |

## Verification
The bench sweeps every combination of mask value, request pattern and enable state, and computes the winner and its vector for each case. A wrong priority order or a swapped mask bit would show up as a wrong take or a wrong address. Directed cases then target behaviour that a sweep does not reach:
- A brief level pulse must be lost, while a brief edge on the highest line must be kept.
- A line held high after service must not trigger again.
- An enable and a disable in the same cycle must leave the enable cleared.
- A boundary during the acknowledge pulse must not start a second one.
- Both a restart byte and a non-restart byte are latched.

Each of these corner cases would expose a specific fault:
- A design that latched the level lines would take a request that has already gone.
- A design that never cleared the enable on acceptance would nest interrupts.
- A design that sampled the bus one cycle late would deliver the wrong opcode.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int MASK_W = 3;
  localparam int NSRC   = MASK_W + 1;
  // source index = priority, highest index wins
  localparam int SRC_GEN = 0;
  localparam int SRC_LO  = 1;
  localparam int SRC_MID = 2;
  localparam int SRC_HI  = 3;

  typedef enum logic {ACK_IDLE, ACK_PULSE} ack_state_e;

  // restart line src sits at "line number" src+4, vector = line*8 + 4
  function automatic logic [ADDR_W-1:0] line_vec(input int unsigned src);
    return ADDR_W'((src + 4) * 8 + 4);
  endfunction

  function automatic logic is_restart_op(input logic [DATA_W-1:0] op);
    return (op[7:6] == 2'b11) && (op[2:0] == 3'b111);
  endfunction

  function automatic logic [ADDR_W-1:0] restart_op_vec(input logic [DATA_W-1:0] op);
    return ADDR_W'({op[5:3], 3'b000});
  endfunction
endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ei_i,
  input  logic              di_i,
  input  logic              ack_i,
  input  logic              mask_we_i,
  input  logic [MASK_W-1:0] mask_wdata_i,
  output logic              ie_o,
  output logic [MASK_W-1:0] mask_o
);
  logic              ie_q;
  logic [MASK_W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      mask_q <= '1;
    end else begin
      if (ack_i || di_i) ie_q <= 1'b0;
      else if (ei_i)     ie_q <= 1'b1;
      if (mask_we_i) mask_q <= mask_wdata_i;
    end
  end

  assign ie_o   = ie_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic clear_i,
  output logic rise_o,
  output logic pend_o
);
  logic prev_q;
  logic pend_q;

  assign rise_o = level_i && !prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= level_i;
      // a fresh edge in the clearing cycle survives
      pend_q <= rise_o || (pend_q && !clear_i);
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_lane
      if (i == N - 1) begin : g_top
        assign grant_o[i] = req_i[i];
      end else begin : g_low
        assign grant_o[i] = req_i[i] && !(|req_i[N-1:i+1]);
      end
    end
  endgenerate
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
  import irq_pkg::*;
#(
  parameter int PULSE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              inta_n_o,
  output logic              busy_o,
  output logic              cap_fire_o,
  output logic              op_valid_o,
  output logic [DATA_W-1:0] opcode_o
);
  localparam int CNT_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;

  ack_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              op_valid_q;
  logic [DATA_W-1:0] opcode_q;
  logic              last_w;

  assign last_w = (state_q == ACK_PULSE) && (cnt_q == CNT_W'(PULSE_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ACK_IDLE;
      cnt_q      <= '0;
      op_valid_q <= 1'b0;
      opcode_q   <= '0;
    end else begin
      op_valid_q <= 1'b0;
      case (state_q)
        ACK_IDLE: begin
          if (start_i) begin
            state_q <= ACK_PULSE;
            cnt_q   <= '0;
          end
        end
        ACK_PULSE: begin
          if (last_w) begin
            state_q    <= ACK_IDLE;
            op_valid_q <= 1'b1;
            opcode_q   <= data_i;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ACK_IDLE;
      endcase
    end
  end

  assign inta_n_o   = (state_q != ACK_PULSE);
  assign busy_o     = (state_q == ACK_PULSE);
  assign cap_fire_o = last_w;
  assign op_valid_o = op_valid_q;
  assign opcode_o   = opcode_q;
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit
  import irq_pkg::*;
#(
  parameter int PULSE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ei_i,
  input  logic              di_i,
  input  logic              mask_we_i,
  input  logic [MASK_W-1:0] mask_wdata_i,
  input  logic              irq_hi_i,
  input  logic              irq_mid_i,
  input  logic              irq_lo_i,
  input  logic              intr_i,
  input  logic              boundary_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              take_o,
  output logic              ie_o,
  output logic              inta_n_o,
  output logic              busy_o,
  output logic              vec_valid_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              op_valid_o,
  output logic [DATA_W-1:0] opcode_o
);
  logic              ie_w;
  logic [MASK_W-1:0] mask_w;
  logic              hi_rise_w;
  logic              hi_pend_w;
  logic [NSRC-1:0]   req_w;
  logic [NSRC-1:0]   grant_w;
  logic              take_w;
  logic              busy_w;
  logic              cap_fire_w;
  logic              vec_valid_q;
  logic [ADDR_W-1:0] vec_addr_q;

  irq_enable_reg u_en (
    .clk(clk), .rst_n(rst_n), .ei_i(ei_i), .di_i(di_i), .ack_i(take_w),
    .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i),
    .ie_o(ie_w), .mask_o(mask_w)
  );

  irq_edge_latch u_hi (
    .clk(clk), .rst_n(rst_n), .level_i(irq_hi_i),
    .clear_i(take_w && grant_w[SRC_HI]),
    .rise_o(hi_rise_w), .pend_o(hi_pend_w)
  );

  assign req_w[SRC_HI]  = ie_w && !mask_w[2] && hi_pend_w;
  assign req_w[SRC_MID] = ie_w && !mask_w[1] && irq_mid_i;
  assign req_w[SRC_LO]  = ie_w && !mask_w[0] && irq_lo_i;
  assign req_w[SRC_GEN] = ie_w && intr_i;

  irq_prio_arb #(.N(NSRC)) u_arb (.req_i(req_w), .grant_o(grant_w));

  assign take_w = boundary_i && !busy_w && (|req_w);

  irq_ack_fsm #(.PULSE_CYC(PULSE_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(take_w && grant_w[SRC_GEN]),
    .data_i(data_i), .inta_n_o(inta_n_o), .busy_o(busy_w),
    .cap_fire_o(cap_fire_w), .op_valid_o(op_valid_o), .opcode_o(opcode_o)
  );

  function automatic logic [ADDR_W-1:0] grant_vec(input logic [NSRC-1:0] g);
    logic [ADDR_W-1:0] v;
    v = '0;
    for (int s = 1; s < NSRC; s++) begin
      if (g[s]) v = line_vec(s);
    end
    return v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid_q <= 1'b0;
      vec_addr_q  <= '0;
    end else if (take_w && !grant_w[SRC_GEN]) begin
      vec_valid_q <= 1'b1;
      vec_addr_q  <= grant_vec(grant_w);
    end else if (cap_fire_w && is_restart_op(data_i)) begin
      vec_valid_q <= 1'b1;
      vec_addr_q  <= restart_op_vec(data_i);
    end else begin
      vec_valid_q <= 1'b0;
    end
  end

  assign take_o      = take_w;
  assign ie_o        = ie_w;
  assign busy_o      = busy_w;
  assign vec_valid_o = vec_valid_q;
  assign vec_addr_o  = vec_addr_q;
endmodule

// File: rtl/irq_ack_chk.sv
module irq_ack_chk
  import irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              boundary_i,
  input logic              take_o,
  input logic              ie_o,
  input logic              inta_n_o,
  input logic              vec_valid_o,
  input logic              op_valid_o,
  input logic [NSRC-1:0]   grant_w,
  input logic [MASK_W-1:0] mask_w
);
  // R3
  take_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ie_o);
  // R10
  take_clears_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !ie_o);
  // R11
  no_take_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inta_n_o |-> !take_o);
  // R12
  take_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> boundary_i);
  // R5
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_w));
  // R4
  hi_mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && grant_w[SRC_HI]) |-> !mask_w[2]);
  // R7
  vec_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |=> !vec_valid_o);
  // R8
  pulse_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(inta_n_o) |-> $past(take_o));
  // R8
  op_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_o |-> $past(!inta_n_o));
endmodule

bind irq_ack_unit irq_ack_chk u_chk (
  .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .take_o(take_o),
  .ie_o(ie_o), .inta_n_o(inta_n_o), .vec_valid_o(vec_valid_o),
  .op_valid_o(op_valid_o), .grant_w(grant_w), .mask_w(mask_w)
);

// File: tb/sim_irq_ack_unit.sv
`timescale 1ns/1ps
module sim_irq_ack_unit;
  logic clk = 1'b0;
  logic rst_n;
  logic ei_i, di_i, mask_we_i;
  logic [2:0] mask_wdata_i;
  logic irq_hi_i, irq_mid_i, irq_lo_i, intr_i, boundary_i;
  logic [7:0] data_i;
  logic take_o, ie_o, inta_n_o, busy_o, vec_valid_o, op_valid_o;
  logic [15:0] vec_addr_o;
  logic [7:0] opcode_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  irq_ack_unit #(.PULSE_CYC(2)) u0 (
    .clk(clk), .rst_n(rst_n), .ei_i(ei_i), .di_i(di_i), .mask_we_i(mask_we_i),
    .mask_wdata_i(mask_wdata_i), .irq_hi_i(irq_hi_i), .irq_mid_i(irq_mid_i),
    .irq_lo_i(irq_lo_i), .intr_i(intr_i), .boundary_i(boundary_i), .data_i(data_i),
    .take_o(take_o), .ie_o(ie_o), .inta_n_o(inta_n_o), .busy_o(busy_o),
    .vec_valid_o(vec_valid_o), .vec_addr_o(vec_addr_o), .op_valid_o(op_valid_o),
    .opcode_o(opcode_o)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ei_i = 0; di_i = 0; mask_we_i = 0; mask_wdata_i = 0;
    irq_hi_i = 0; irq_mid_i = 0; irq_lo_i = 0; intr_i = 0; boundary_i = 0; data_i = 0;
    nxt(); nxt();
    rst_n = 1'b1;
  endtask

  task automatic pulse_ei();
    ei_i = 1; nxt(); ei_i = 0;
  endtask

  task automatic write_mask(input logic [2:0] m);
    mask_we_i = 1; mask_wdata_i = m; nxt(); mask_we_i = 0;
  endtask

  // general request with byte b; checks the whole acknowledge sequence
  task automatic gen_seq(input logic [7:0] b);
    boundary_i = 1; data_i = b; #1;
    chk(take_o == 1'b1, "R8 take", {31'd0, take_o}, 1);
    nxt(); boundary_i = 0; intr_i = 0;
    chk(inta_n_o == 1'b0, "R8 low1", {31'd0, inta_n_o}, 0);
    chk(ie_o == 1'b0, "R10 ie", {31'd0, ie_o}, 0);
    nxt();
    chk(inta_n_o == 1'b0, "R8 low2", {31'd0, inta_n_o}, 0);
    nxt(); data_i = 8'h00;
    chk(inta_n_o == 1'b1 && op_valid_o == 1'b1, "R8 opv", {30'd0, inta_n_o, op_valid_o}, 3);
    chk(opcode_o == b, "R8 opcode", {24'd0, opcode_o}, {24'd0, b});
    if (b[7:6] == 2'b11 && b[2:0] == 3'b111)
      chk(vec_valid_o && vec_addr_o == 16'(b[5:3]) * 16'd8, "R9 rstop",
          {15'd0, vec_valid_o, vec_addr_o}, {16'd1, 16'(b[5:3]) * 16'd8});
    else
      chk(vec_valid_o == 1'b0, "R9 nonrst", {31'd0, vec_valid_o}, 0);
    nxt();
    chk(op_valid_o == 1'b0, "R8 opv drop", {31'd0, op_valid_o}, 0);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    do_reset();
    nxt();
    // R1 reset state
    chk(ie_o == 0 && inta_n_o == 1 && vec_valid_o == 0 && op_valid_o == 0 && take_o == 0,
        "R1 reset", {27'd0, ie_o, inta_n_o, vec_valid_o, op_valid_o, take_o}, 32'h08);
    // R1: mask resets all-blocking
    pulse_ei(); irq_lo_i = 1; irq_mid_i = 1; nxt(); boundary_i = 1; #1;
    chk(take_o == 0, "R1 mask reset", {31'd0, take_o}, 0);
    boundary_i = 0; irq_lo_i = 0; irq_mid_i = 0;

    // R2 enable / disable
    do_reset(); nxt();
    ei_i = 1; di_i = 1; nxt(); ei_i = 0; di_i = 0;
    chk(ie_o == 0, "R2 di wins", {31'd0, ie_o}, 0);
    pulse_ei();
    chk(ie_o == 1, "R2 ei", {31'd0, ie_o}, 1);
    di_i = 1; nxt(); di_i = 0;
    chk(ie_o == 0, "R2 di", {31'd0, ie_o}, 0);

    // R12 no boundary: nothing taken
    pulse_ei(); intr_i = 1;
    for (int k = 0; k < 3; k++) begin
      nxt();
      chk(inta_n_o == 1 && ie_o == 1, "R12 no boundary", {30'd0, inta_n_o, ie_o}, 3);
    end

    // R8 R9 R10: general request with a restart byte
    gen_seq(8'hE7);
    intr_i = 1; boundary_i = 1; #1;
    chk(take_o == 0, "R10 ignored until ei", {31'd0, take_o}, 0);
    boundary_i = 0; nxt();
    // R9 non-restart byte
    pulse_ei();
    gen_seq(8'hCD);

    // R11 boundary during pulse
    intr_i = 1; pulse_ei(); boundary_i = 1; nxt();
    chk(inta_n_o == 0, "R11 pulse", {31'd0, inta_n_o}, 0);
    ei_i = 1; nxt(); ei_i = 0; #1;
    chk(take_o == 0, "R11 blocked", {31'd0, take_o}, 0);
    nxt(); #1;
    chk(take_o == 1, "R11 after pulse", {31'd0, take_o}, 1);
    boundary_i = 0; intr_i = 0; nxt(); nxt(); nxt(); nxt();

    // R6 level pulse lost, edge kept
    do_reset(); nxt(); write_mask(3'b000); pulse_ei();
    irq_mid_i = 1; nxt(); irq_mid_i = 0; boundary_i = 1; #1;
    chk(take_o == 0, "R6 level lost", {31'd0, take_o}, 0);
    boundary_i = 0;
    di_i = 1; irq_hi_i = 1; nxt(); di_i = 0; irq_hi_i = 0; nxt(); nxt();
    pulse_ei(); boundary_i = 1; #1;
    chk(take_o == 1, "R6 edge kept", {31'd0, take_o}, 1);
    nxt(); boundary_i = 0;
    chk(vec_valid_o && vec_addr_o == 16'h003C, "R7 hi vec", {15'd0, vec_valid_o, vec_addr_o}, 32'h1003C);
    irq_hi_i = 1; nxt(); nxt();
    pulse_ei(); pulse_ei(); boundary_i = 1; #1;
    chk(take_o == 1, "R6 new edge", {31'd0, take_o}, 1);
    nxt(); boundary_i = 0; pulse_ei(); boundary_i = 1; #1;
    chk(take_o == 0, "R6 held no retrigger", {31'd0, take_o}, 0);
    boundary_i = 0; irq_hi_i = 0;

    // R3 R4 R5 R7 R10 exhaustive sweep
    for (int c = 0; c < 256; c++) begin
      logic [2:0] m; logic [3:0] r; logic e; logic [3:0] el; int win; logic [15:0] ev;
      m = c[2:0]; r = c[6:3]; e = c[7];
      el[3] = e & ~m[2] & r[3];
      el[2] = e & ~m[1] & r[2];
      el[1] = e & ~m[0] & r[1];
      el[0] = e & r[0];
      win = el[3] ? 3 : el[2] ? 2 : el[1] ? 1 : el[0] ? 0 : -1;
      ev = (win == 3) ? 16'h003C : (win == 2) ? 16'h0034 : 16'h002C;
      do_reset(); nxt();
      mask_we_i = 1; mask_wdata_i = m; ei_i = e;
      irq_hi_i = r[3]; irq_mid_i = r[2]; irq_lo_i = r[1]; intr_i = r[0];
      nxt(); mask_we_i = 0; ei_i = 0; boundary_i = 1; #1;
      chk(take_o == (win >= 0), "R5 sweep take", {31'd0, take_o}, {31'd0, win >= 0});
      nxt(); boundary_i = 0;
      if (win > 0)
        chk(vec_valid_o && vec_addr_o == ev, "R7 sweep vec", {15'd0, vec_valid_o, vec_addr_o}, {16'd1, ev});
      else if (win == 0)
        chk(inta_n_o == 0 && vec_valid_o == 0, "R5 sweep gen", {30'd0, inta_n_o, vec_valid_o}, 0);
      else
        chk(inta_n_o == 1 && vec_valid_o == 0, "R4 sweep none", {30'd0, inta_n_o, vec_valid_o}, 2);
      chk(ie_o == ((win >= 0) ? 1'b0 : e), "R10 sweep ie", {31'd0, ie_o}, {31'd0, (win >= 0) ? 1'b0 : e});
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule